// File: doc/BRIEF.md
# Parallel Synchronous Bus Word Assembler

This block watches a parallel data bus of up to eight lines together with the bus clock that accompanies it. On the selected transition of that bus clock, rising or falling, it captures the data lines as one item. When no bus clock is connected, it captures an item whenever the data lines change. All bus inputs are expected to be synchronous to the system clock already. The block samples them once per system-clock cycle.

Captured items are collected into words of a run-time word size, counted in items. Each finished word goes out on a valid/data strobe. The order of items inside the word is selectable. Each item is also reported on its own strobe, but one capture late: an item is held until the next capture, so its span runs from its own capture to the following one. The very first capture after reset therefore gives no item output.

Top module: `par_word_asm`

## Requirements
- R1: While reset is asserted, and in the first system-clock cycle after it is released, `item_vld` and `word_vld` are 0. A bus-clock level or data pattern that is present in that first cycle causes no capture.
- R2: With `clk_present`=1 and `edge_fall`=0, an item is captured only in a cycle where `bus_clk` is 1 and was 0 in the previous cycle. A steady level or a falling transition captures nothing.
- R3: With `clk_present`=1 and `edge_fall`=1, an item is captured only in a cycle where `bus_clk` is 0 and was 1 in the previous cycle.
- R4: With `clk_present`=0, an item is captured in every cycle where `bus_dat` differs from its value in the previous cycle. `bus_clk` is ignored in this mode, and steady data captures nothing.
- R5: The first capture after reset produces no item strobe. Every later capture pulses `item_vld` for one cycle, in the cycle after the capture, and `item_dat` then carries the item from the previous capture.
- R6: A word completes on the capture that brings the item count up to the word size. `word_vld` pulses in the cycle after that capture, and the item count returns to zero. A `word_size` of 0 is treated as 1, and a value above MAX_WS is treated as MAX_WS.
- R7: With `big_end`=0, item i of a word (i counted from 0) occupies bits starting at offset (ws-1-i)*8. The first item therefore lands in the most significant used slot. Bits above ws*8 are 0.
- R8: With `big_end`=1, item i occupies bits starting at offset i*8. The first item therefore lands in bits [7:0].
- R9: `word_size` and `big_end` are taken at the first item of a word. Changing them before that word completes has no effect on it.
- R10: Data line k forms bit k of an item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus clock line |
| bus_dat | input | DW | Bus data lines |
| clk_present | input | 1 | 1: bus clock is connected; 0: capture on data change |
| edge_fall | input | 1 | 0: capture on the rising edge; 1: capture on the falling edge |
| word_size | input | $clog2(MAX_WS+1) | Items per word |
| big_end | input | 1 | 0: first item most significant; 1: first item least significant |
| item_vld | output | 1 | Item strobe |
| item_dat | output | DW | Item reported one capture late |
| word_vld | output | 1 | Word strobe |
| word_dat | output | MAX_WS*DW | Assembled word, unused upper bits zero |

## Verification
A capture is decided in the system-clock cycle where the new bus-clock level or the changed data is first seen. The item strobe and the word strobe from that capture are registered, so both appear exactly one cycle later and last one cycle. The bench drives inputs on the falling clock edge. Its behavioural model advances on every rising edge, and the outputs are compared against it on the next falling edge, which is where that one-cycle latency puts them. Strobe counts over each scenario are also checked against figures worked out by hand.

// File: rtl/par_word_pkg.sv
package par_word_pkg;
  // Map a requested word size onto the supported range 1..max_ws.
  function automatic int clamp_ws(int req, int max_ws);
    if (req < 1) return 1;
    if (req > max_ws) return max_ws;
    return req;
  endfunction
endpackage

// File: rtl/pws_edge_det.sv
module pws_edge_det #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clk,
  input  logic [DW-1:0] bus_dat,
  input  logic          clk_present,
  input  logic          edge_fall,
  output logic          cap
);
  logic          prev_clk_q, prev_clk_d;
  logic [DW-1:0] prev_dat_q, prev_dat_d;
  logic          prev_ok_q,  prev_ok_d;
  logic          clk_hit, dat_hit;

  always_comb begin
    prev_clk_d = bus_clk;
    prev_dat_d = bus_dat;
    prev_ok_d  = 1'b1;
    clk_hit    = edge_fall ? (prev_clk_q & ~bus_clk) : (~prev_clk_q & bus_clk);
    dat_hit    = (bus_dat != prev_dat_q);
    cap        = prev_ok_q & (clk_present ? clk_hit : dat_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk_q <= 1'b0;
      prev_dat_q <= '0;
      prev_ok_q  <= 1'b0;
    end else begin
      prev_clk_q <= prev_clk_d;
      prev_dat_q <= prev_dat_d;
      prev_ok_q  <= prev_ok_d;
    end
  end
endmodule

// File: rtl/pws_item_hold.sv
module pws_item_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] dat,
  output logic          item_vld,
  output logic [DW-1:0] item_dat,
  output logic          first_pend
);
  logic [DW-1:0] held_q, held_d;
  logic          first_d;
  logic          vld_d;
  logic [DW-1:0] out_d;

  always_comb begin
    held_d  = held_q;
    first_d = first_pend;
    vld_d   = 1'b0;
    out_d   = item_dat;
    if (cap) begin
      held_d  = dat;
      first_d = 1'b0;
      if (!first_pend) begin
        vld_d = 1'b1;
        out_d = held_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= '0;
      first_pend <= 1'b1;
      item_vld   <= 1'b0;
      item_dat   <= '0;
    end else begin
      held_q     <= held_d;
      first_pend <= first_d;
      item_vld   <= vld_d;
      item_dat   <= out_d;
    end
  end
endmodule

// File: rtl/pws_word_pack.sv
module pws_word_pack
  import par_word_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MAX_WS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap,
  input  logic [DW-1:0]                dat,
  input  logic [$clog2(MAX_WS+1)-1:0]  word_size,
  input  logic                         big_end,
  output logic                         word_vld,
  output logic [MAX_WS*DW-1:0]         word_dat,
  output logic [$clog2(MAX_WS+1)-1:0]  cnt,
  output logic [$clog2(MAX_WS+1)-1:0]  ws_lat
);
  localparam int CW = $clog2(MAX_WS + 1);
  localparam int WW = MAX_WS * DW;

  logic [WW-1:0] acc_q, acc_d, filled;
  logic [CW-1:0] cnt_d, ws_lat_d, ws_use, slot;
  logic          be_q, be_d, be_use, last;
  logic          wv_d;
  logic [WW-1:0] wd_d;

  always_comb begin
    ws_use = (cnt == '0) ? CW'(clamp_ws(int'(word_size), MAX_WS)) : ws_lat;
    be_use = (cnt == '0) ? big_end : be_q;
    slot   = be_use ? cnt : CW'(ws_use - 1'b1 - cnt);
    last   = (cnt == CW'(ws_use - 1'b1));
  end

  // One insertion mux per item slot of the word.
  for (genvar s = 0; s < MAX_WS; s++) begin : g_slot
    assign filled[s*DW +: DW] = (cap && slot == CW'(s)) ? dat : acc_q[s*DW +: DW];
  end

  always_comb begin
    acc_d    = acc_q;
    cnt_d    = cnt;
    ws_lat_d = ws_lat;
    be_d     = be_q;
    wv_d     = 1'b0;
    wd_d     = word_dat;
    if (cap) begin
      ws_lat_d = ws_use;
      be_d     = be_use;
      if (last) begin
        acc_d = '0;
        cnt_d = '0;
        wv_d  = 1'b1;
        wd_d  = filled;
      end else begin
        acc_d = filled;
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt      <= '0;
      ws_lat   <= CW'(1);
      be_q     <= 1'b0;
      word_vld <= 1'b0;
      word_dat <= '0;
    end else begin
      acc_q    <= acc_d;
      cnt      <= cnt_d;
      ws_lat   <= ws_lat_d;
      be_q     <= be_d;
      word_vld <= wv_d;
      word_dat <= wd_d;
    end
  end
endmodule

// File: rtl/par_word_asm.sv
module par_word_asm #(
  parameter int DW     = 8,
  parameter int MAX_WS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_clk,
  input  logic [DW-1:0]                bus_dat,
  input  logic                         clk_present,
  input  logic                         edge_fall,
  input  logic [$clog2(MAX_WS+1)-1:0]  word_size,
  input  logic                         big_end,
  output logic                         item_vld,
  output logic [DW-1:0]                item_dat,
  output logic                         word_vld,
  output logic [MAX_WS*DW-1:0]         word_dat
);
  localparam int CW = $clog2(MAX_WS + 1);

  logic          cap;
  logic          first_pend;
  logic [CW-1:0] cnt, ws_lat;

  pws_edge_det #(.DW(DW)) u_edge (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .clk_present(clk_present), .edge_fall(edge_fall), .cap(cap)
  );

  pws_item_hold #(.DW(DW)) u_item (
    .clk(clk), .rst_n(rst_n), .cap(cap), .dat(bus_dat),
    .item_vld(item_vld), .item_dat(item_dat), .first_pend(first_pend)
  );

  pws_word_pack #(.DW(DW), .MAX_WS(MAX_WS)) u_word (
    .clk(clk), .rst_n(rst_n), .cap(cap), .dat(bus_dat),
    .word_size(word_size), .big_end(big_end),
    .word_vld(word_vld), .word_dat(word_dat), .cnt(cnt), .ws_lat(ws_lat)
  );
endmodule

// File: rtl/pws_chk.sv
module pws_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_clk,
  input logic [DW-1:0] bus_dat,
  input logic          clk_present,
  input logic          edge_fall,
  input logic          cap,
  input logic          first_pend,
  input logic          item_vld,
  input logic          word_vld,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] ws_lat
);
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present && !edge_fall && cap) |-> (bus_clk && !$past(bus_clk))); // R2
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present && edge_fall && cap) |-> (!bus_clk && $past(bus_clk))); // R3
  AST_NOCLK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_present && cap) |-> (bus_dat != $past(bus_dat))); // R4
  AST_ITEM_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    item_vld |-> $past(cap)); // R5
  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap) && $past(first_pend)) |-> !item_vld); // R5
  AST_WORD_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(cap)); // R6
  AST_CNT_BELOW_WS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ws_lat); // R6
endmodule

bind par_word_asm pws_chk #(.DW(DW), .CW($clog2(MAX_WS+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
  .clk_present(clk_present), .edge_fall(edge_fall), .cap(cap),
  .first_pend(first_pend), .item_vld(item_vld), .word_vld(word_vld),
  .cnt(cnt), .ws_lat(ws_lat)
);

// File: tb/par_word_asm_tb.sv
module par_word_asm_tb;
  localparam int DW = 8;
  localparam int MAX_WS = 4;
  localparam int CW = $clog2(MAX_WS + 1);
  localparam int WW = MAX_WS * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_clk = 1'b0;
  logic [DW-1:0] bus_dat = '0;
  logic          clk_present = 1'b1;
  logic          edge_fall = 1'b0;
  logic [CW-1:0] word_size = CW'(1);
  logic          big_end = 1'b0;
  logic          item_vld, word_vld;
  logic [DW-1:0] item_dat;
  logic [WW-1:0] word_dat;

  always #5 clk = ~clk;

  par_word_asm #(.DW(DW), .MAX_WS(MAX_WS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .clk_present(clk_present), .edge_fall(edge_fall), .word_size(word_size),
    .big_end(big_end), .item_vld(item_vld), .item_dat(item_dat),
    .word_vld(word_vld), .word_dat(word_dat)
  );

  int n_chk = 0, n_fail = 0, n_items = 0, n_words = 0;
  string cur_req = "R1";
  bit done = 0;

  // Behavioural reference model
  bit            m_ok, m_pclk, m_first;
  logic [DW-1:0] m_pdat, m_held;
  logic [DW-1:0] q[$];
  int            m_ws;
  bit            m_be;
  bit            e_ivld, e_wvld;
  logic [DW-1:0] e_item;
  logic [WW-1:0] e_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ok = 0; m_first = 1; q.delete();
      e_ivld = 0; e_wvld = 0;
    end else begin
      bit hit;
      e_ivld = 0; e_wvld = 0;
      if (clk_present) hit = edge_fall ? (m_pclk && !bus_clk) : (!m_pclk && bus_clk);
      else hit = (bus_dat !== m_pdat);
      if (m_ok && hit) begin
        if (m_first) m_first = 0;
        else begin e_ivld = 1; e_item = m_held; end
        m_held = bus_dat;
        if (q.size() == 0) begin
          m_ws = (word_size == 0) ? 1 : (int'(word_size) > MAX_WS ? MAX_WS : int'(word_size));
          m_be = big_end;
        end
        q.push_back(bus_dat);
        if (q.size() == m_ws) begin
          e_word = '0;
          for (int i = 0; i < m_ws; i++)
            e_word |= WW'(q[i]) << ((m_be ? i : (m_ws - 1 - i)) * DW);
          e_wvld = 1;
          q.delete();
        end
      end
      m_ok = 1; m_pclk = bus_clk; m_pdat = bus_dat;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "item_vld", item_vld, e_ivld);
      if (e_ivld) check(cur_req, "item_dat", item_dat, e_item);
      check(cur_req, "word_vld", word_vld, e_wvld);
      if (e_wvld) check(cur_req, "word_dat", word_dat, e_word);
      if (item_vld) n_items++;
      if (word_vld) n_words++;
    end
  end

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1", "item_vld in reset", item_vld, 0);
    check("R1", "word_vld in reset", word_vld, 0);
    rst_n = 1;
    n_items = 0; n_words = 0;
  endtask

  task automatic bus_cyc(input logic [DW-1:0] d);
    @(negedge clk) bus_dat = d; bus_clk = 0;
    repeat (2) @(negedge clk);
    bus_clk = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R1: high clock level present when reset releases must not capture
    bus_clk = 1; clk_present = 1; edge_fall = 0;
    do_reset();
    repeat (3) @(negedge clk);
    check("R1", "no words after release", n_words, 0);

    // R2 R10 R5: rising edge, one item per word
    cur_req = "R2"; bus_clk = 0; word_size = 1; big_end = 0;
    do_reset();
    bus_cyc(8'h01); bus_cyc(8'h80); bus_cyc(8'hA5); bus_cyc(8'h3C);
    repeat (3) @(negedge clk);
    check("R2", "word count", n_words, 4);
    check("R5", "item count one late", n_items, 3);
    cur_req = "R10";
    bus_cyc(8'h02); bus_cyc(8'h40);

    // R3: falling edge, two items, little order (R7)
    cur_req = "R3"; edge_fall = 1; word_size = 2; big_end = 0;
    do_reset();
    bus_cyc(8'h11); bus_cyc(8'h22); bus_cyc(8'h33); bus_cyc(8'h44);
    @(negedge clk) bus_clk = 0;
    repeat (3) @(negedge clk);
    check("R3", "word count", n_words, 2);

    // R8: big order, three items
    cur_req = "R8"; edge_fall = 0; word_size = 3; big_end = 1;
    do_reset();
    for (int k = 0; k < 6; k++) bus_cyc(DW'(8'h10 + k));
    repeat (3) @(negedge clk);
    check("R8", "word count", n_words, 2);

    // R7: little order, four items
    cur_req = "R7"; word_size = 4; big_end = 0;
    do_reset();
    for (int k = 0; k < 4; k++) bus_cyc(DW'(8'hC0 + k));
    repeat (2) @(negedge clk);
    check("R7", "word count", n_words, 1);

    // R6: size 0 acts as 1, size 7 acts as MAX_WS
    cur_req = "R6"; word_size = 0;
    do_reset();
    bus_cyc(8'h5A); bus_cyc(8'hA5);
    repeat (2) @(negedge clk);
    check("R6", "size 0 words", n_words, 2);
    word_size = 7;
    do_reset();
    for (int k = 0; k < 8; k++) bus_cyc(DW'(8'h70 + k));
    repeat (2) @(negedge clk);
    check("R6", "size 7 words", n_words, 2);

    // R9: mid-word changes ignored
    cur_req = "R9"; word_size = 3; big_end = 0;
    do_reset();
    bus_cyc(8'hE1);
    word_size = 1; big_end = 1;
    bus_cyc(8'hE2); bus_cyc(8'hE3);
    repeat (2) @(negedge clk);
    check("R9", "one word of three", n_words, 1);
    bus_cyc(8'hE4);
    repeat (2) @(negedge clk);
    check("R9", "new size at next word", n_words, 2);

    // R4: no bus clock, capture on data change
    cur_req = "R4"; clk_present = 0; word_size = 2; big_end = 1;
    do_reset();
    @(negedge clk) bus_dat = 8'h01;
    @(negedge clk) bus_dat = 8'h02; bus_clk = ~bus_clk;
    @(negedge clk) bus_clk = ~bus_clk;
    @(negedge clk) bus_clk = ~bus_clk;
    @(negedge clk) bus_dat = 8'h03;
    @(negedge clk) bus_dat = 8'h04;
    repeat (3) @(negedge clk);
    check("R4", "word count", n_words, 2);
    check("R4", "item count", n_items, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule